// File: doc/BRIEF.md
# Dual-Channel Strobed Code Loader

This block is the digital front end for a pair of 12-bit converter channels that share one data bus and one write strobe. Each channel has its own active-low select. The block samples the strobe, the selects and the bus in the system clock domain through a synchronizer. It then looks for a low-to-high transition of the synchronized strobe. On that transition it copies the bus word into channel A's held code, channel B's held code, or both.

Each channel also drives a single-cycle update pulse. The pulse marks the cycle in which that channel's held code first shows a newly written word. Downstream logic can use it to start a conversion or to log the change. A single write with both selects active broadcasts the same word to the two channels, so both channels can be set to a common value in one bus cycle.

Top module: `dual_code_loader`

## Requirements
- R1: While reset is asserted and after it is released, both held codes read zero and both update pulses stay low until the first write.
- R2: A word is captured only on the low-to-high transition of the write strobe. The value captured is the bus word present at that transition. Bus changes while the strobe sits low do not alter any held code.
- R3: With select bit 0 (channel A) low and select bit 1 high at the transition, only channel A's code (output bits 11:0) is loaded. Channel B's code stays unchanged.
- R4: With select bit 1 (channel B) low and select bit 0 high at the transition, only channel B's code (output bits 23:12) is loaded. Channel A's code stays unchanged.
- R5: With both select bits low at the transition, the same bus word is written to both channels, and both update pulses rise in the same cycle.
- R6: With both select bits high at the transition, neither code changes and neither update pulse rises.
- R7: While the write strobe holds a constant level (high or low), toggling the selects or the bus changes no code and raises no pulse.
- R8: Each update pulse is high for exactly one clock cycle per write. It rises in the same cycle in which the new code first appears on that channel's output.
- R9: The new code and its pulse are visible after the second rising clock edge that follows the edge which first samples the strobe high.
- R10: Within each held code, bus bit 11 is the MSB and bit 0 is the LSB. Words of all ones and all zeros are held unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_i | input | 1 | Shared write strobe; capture occurs on its rising transition |
| sel_n_i | input | 2 | Active-low channel selects; bit 0 is channel A, bit 1 is channel B |
| bus_i | input | 12 | Shared data word, bit 11 MSB |
| code_o | output | 24 | Held codes; bits 11:0 channel A, bits 23:12 channel B |
| upd_o | output | 2 | Single-cycle update pulses; bit 0 channel A, bit 1 channel B |

## Verification
The bench builds the block with its default values: a 12-bit word and a two-stage synchronizer. With these values the capture latency is fixed and known, so the bench can test the exact update cycle and pulse width. The 12-bit width lets it write all-ones, all-zeros, single-MSB and single-LSB words. With the selects sharing the synchronizer with the strobe, every select combination at the strobe edge can be reached, and so can select and bus toggling while the strobe holds still.

// File: rtl/dcl_pkg.sv
package dcl_pkg;

  // number of channels sharing the bus; select and pulse vectors use this
  localparam int NUM_CH = 2;
  localparam int CH_A   = 0;
  localparam int CH_B   = 1;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_A    = 2'd1,
    TGT_B    = 2'd2,
    TGT_BOTH = 2'd3
  } target_e;

  // map a detected edge and the sampled active-low selects to a write target
  function automatic target_e decode_target(input logic rise,
                                            input logic [NUM_CH-1:0] sel_n);
    target_e t;
    t = TGT_NONE;
    if (rise) begin
      unique case (sel_n)
        2'b10:   t = TGT_A;
        2'b01:   t = TGT_B;
        2'b00:   t = TGT_BOTH;
        default: t = TGT_NONE;
      endcase
    end
    return t;
  endfunction

  function automatic logic target_hits(input target_e t, input int ch);
    logic hit;
    hit = 1'b0;
    if (t == TGT_BOTH) hit = 1'b1;
    else if (t == TGT_A && ch == CH_A) hit = 1'b1;
    else if (t == TGT_B && ch == CH_B) hit = 1'b1;
    return hit;
  endfunction

endpackage

// File: rtl/dcl_rst_sync.sv
module dcl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] pipe_q;
  logic [1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= 2'b00;
    else        pipe_q <= pipe_d;
  end

  assign rst_sync_n = pipe_q[1];
endmodule

// File: rtl/dcl_sync.sv
module dcl_sync #(
  parameter int          W       = 8,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_comb stg_d[g] = din_i;
    end else begin : g_next
      always_comb stg_d[g] = stg_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= RST_VAL;
      else        stg_q[g] <= stg_d[g];
    end
  end

  assign dout_o = stg_q[STAGES-1];
endmodule

// File: rtl/dcl_edge.sv
module dcl_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;
  logic prev_d;

  always_comb prev_d = lvl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= prev_d;
  end

  assign rise_o = lvl_i & ~prev_q;

  // R8
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

  // R7
  rise_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(lvl_i) |=> !rise_o || $changed(lvl_i));
endmodule

// File: rtl/dcl_hold_reg.sv
module dcl_hold_reg #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] code_o,
  output logic              upd_o
);
  logic [DATA_W-1:0] code_q, code_d;
  logic              upd_q, upd_d;

  always_comb begin
    code_d = code_q;
    upd_d  = 1'b0;
    if (load_i) begin
      code_d = din_i;
      upd_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      if (load_i) code_q <= code_d;
      upd_q <= upd_d;
    end
  end

  assign code_o = code_q;
  assign upd_o  = upd_q;

  // R2
  capture_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (code_o == $past(din_i)) && upd_o);

  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(code_o) && !upd_o);
endmodule

// File: rtl/dual_code_loader.sv
module dual_code_loader
  import dcl_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_i,
  input  logic [1:0]               sel_n_i,
  input  logic [DATA_W-1:0]        bus_i,
  output logic [2*DATA_W-1:0]      code_o,
  output logic [1:0]               upd_o
);
  localparam int SW = 1 + NUM_CH + DATA_W;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, {NUM_CH{1'b1}}, {DATA_W{1'b0}}};

  logic              rst_int_n;
  logic [SW-1:0]     raw_in, synced;
  logic              wr_s;
  logic [NUM_CH-1:0] sel_s;
  logic [DATA_W-1:0] bus_s;
  logic              rise;
  target_e           tgt;
  logic [NUM_CH-1:0] load_en;

  dcl_rst_sync i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign raw_in = {wr_i, sel_n_i, bus_i};

  // strobe, selects and bus share one pipeline so they stay aligned
  dcl_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) i_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .din_i  (raw_in),
    .dout_o (synced)
  );

  assign wr_s  = synced[SW-1];
  assign sel_s = synced[DATA_W +: NUM_CH];
  assign bus_s = synced[DATA_W-1:0];

  dcl_edge i_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .lvl_i  (wr_s),
    .rise_o (rise)
  );

  always_comb tgt = decode_target(rise, sel_s);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb load_en[c] = target_hits(tgt, c);

    dcl_hold_reg #(.DATA_W(DATA_W)) i_reg (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .load_i (load_en[c]),
      .din_i  (bus_s),
      .code_o (code_o[c*DATA_W +: DATA_W]),
      .upd_o  (upd_o[c])
    );
  end

  // R5
  bcast_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rise && sel_s == 2'b00) |=>
      (upd_o == 2'b11) && (code_o[DATA_W-1:0] == code_o[2*DATA_W-1:DATA_W]));

  // R3
  only_a_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rise && sel_s == 2'b10) |=>
      (upd_o == 2'b01) && $stable(code_o[2*DATA_W-1:DATA_W]));

  // R4
  only_b_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rise && sel_s == 2'b01) |=>
      (upd_o == 2'b10) && $stable(code_o[DATA_W-1:0]));

  // R6
  no_sel_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rise && sel_s == 2'b11) |=> (upd_o == 2'b00) && $stable(code_o));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_int_n |-> (code_o == '0) && (upd_o == 2'b00));
endmodule

// File: tb/test_dual_code_loader.sv
module test_dual_code_loader;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_i;
  logic [1:0]  sel_n_i;
  logic [11:0] bus_i;
  logic [23:0] code_o;
  logic [1:0]  upd_o;

  int total = 0;
  int bad   = 0;
  bit mon_on = 1'b0;
  bit done   = 1'b0;

  typedef struct { int ch; logic [11:0] d; } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  dual_code_loader i_dual_code_loader (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_i),
    .sel_n_i (sel_n_i),
    .bus_i   (bus_i),
    .code_o  (code_o),
    .upd_o   (upd_o)
  );

  function automatic logic [11:0] chan(input int ch);
    return (ch == 0) ? code_o[11:0] : code_o[23:12];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input int ch, input logic [11:0] d);
    exp_t e;
    e.ch = ch;
    e.d  = d;
    exp_q.push_back(e);
  endtask

  // monitor: every update pulse must match the oldest expected write (R2, R8)
  always @(negedge clk) begin
    if (mon_on) begin
      for (int c = 0; c < 2; c++) begin
        if (upd_o[c]) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R8 unexpected update pulse on channel", c, 32'hFFFF);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.ch == c, "R2 pulse channel", c, e.ch);
            chk(chan(c) == e.d, "R2 captured code", chan(c), e.d);
          end
        end
      end
    end
  end

  task automatic do_write(input logic [1:0] sel, input logic [11:0] d);
    @(negedge clk);
    sel_n_i = sel;
    bus_i   = d;
    wr_i    = 1'b0;
    repeat (4) @(negedge clk);
    wr_i = 1'b1;
    if (!sel[0]) push(0, d);
    if (!sel[1]) push(1, d);
    repeat (5) @(negedge clk);
    sel_n_i = 2'b11;
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [23:0] snap;
    rst_n   = 1'b0;
    wr_i    = 1'b1;
    sel_n_i = 2'b11;
    bus_i   = 12'h000;
    repeat (3) @(negedge clk);
    chk(code_o == 24'h0, "R1 code in reset", code_o, 24'h0);
    chk(upd_o == 2'b00, "R1 pulse in reset", upd_o, 2'b00);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(code_o == 24'h0, "R1 code after release", code_o, 24'h0);
    chk(upd_o == 2'b00, "R1 pulse after release", upd_o, 2'b00);
    mon_on = 1'b1;

    // R3: channel A only
    do_write(2'b10, 12'hA5C);
    chk(code_o[23:12] == 12'h000, "R3 channel B untouched", code_o[23:12], 12'h000);
    chk(code_o[11:0] == 12'hA5C, "R3 channel A loaded", code_o[11:0], 12'hA5C);

    // R4: channel B only
    do_write(2'b01, 12'h3E1);
    chk(code_o[11:0] == 12'hA5C, "R4 channel A untouched", code_o[11:0], 12'hA5C);
    chk(code_o[23:12] == 12'h3E1, "R4 channel B loaded", code_o[23:12], 12'h3E1);

    // R5: broadcast
    do_write(2'b00, 12'h7FF);
    chk(code_o == {12'h7FF, 12'h7FF}, "R5 broadcast", code_o, {12'h7FF, 12'h7FF});

    // R6: no select
    do_write(2'b11, 12'h123);
    chk(code_o == {12'h7FF, 12'h7FF}, "R6 no select holds", code_o, {12'h7FF, 12'h7FF});

    // R7: strobe held high, selects and bus toggling
    snap = code_o;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      sel_n_i = i[1:0];
      bus_i   = 12'h111 * i[3:0];
    end
    sel_n_i = 2'b11;
    repeat (4) @(negedge clk);
    chk(code_o == snap, "R7 strobe high constant", code_o, snap);

    // R2/R7: strobe held low, bus changing; capture only at the rise
    @(negedge clk);
    sel_n_i = 2'b10;
    wr_i    = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      bus_i = 12'h0F0 + i[11:0];
    end
    repeat (3) @(negedge clk);
    chk(code_o == snap, "R2 no capture while strobe low", code_o, snap);
    bus_i = 12'h9C3;
    repeat (3) @(negedge clk);
    wr_i = 1'b1;
    push(0, 12'h9C3);
    repeat (5) @(negedge clk);
    sel_n_i = 2'b11;
    chk(code_o[11:0] == 12'h9C3, "R2 captured at rise", code_o[11:0], 12'h9C3);

    // R9/R8: latency and pulse width on channel B
    @(negedge clk);
    sel_n_i = 2'b01;
    bus_i   = 12'h801;
    wr_i    = 1'b0;
    repeat (4) @(negedge clk);
    wr_i = 1'b1;
    push(1, 12'h801);
    @(negedge clk);
    chk(upd_o[1] == 1'b0, "R9 pulse not yet after first edge", upd_o[1], 1'b0);
    @(negedge clk);
    chk(upd_o[1] == 1'b0, "R9 pulse not yet after second edge", upd_o[1], 1'b0);
    @(negedge clk);
    chk(upd_o[1] == 1'b1, "R9 pulse after third edge", upd_o[1], 1'b1);
    chk(code_o[23:12] == 12'h801, "R8 code with pulse", code_o[23:12], 12'h801);
    @(negedge clk);
    chk(upd_o[1] == 1'b0, "R8 pulse one cycle", upd_o[1], 1'b0);
    repeat (2) @(negedge clk);
    sel_n_i = 2'b11;

    // R10: extreme words
    do_write(2'b01, 12'hFFF);
    chk(code_o[23:12] == 12'hFFF, "R10 all ones", code_o[23:12], 12'hFFF);
    do_write(2'b10, 12'h001);
    chk(code_o[11:0] == 12'h001, "R10 LSB only", code_o[11:0], 12'h001);
    do_write(2'b00, 12'h000);
    chk(code_o == 24'h0, "R10 all zeros broadcast", code_o, 24'h0);
    do_write(2'b10, 12'h800);
    chk(code_o[11:0] == 12'h800, "R10 MSB only", code_o[11:0], 12'h800);

    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R8 every expected write seen", exp_q.size(), 0);
    finish_run();
  end
endmodule